// File: doc/BRIEF.md
# Host Port Ready Status Tracker

This block produces the ready indication for a host-side data port that sits in front of a write FIFO and a prefetching read FIFO. It records the kind of the most recent host data access: read or write, auto-increment or fixed-address, or a prefetch command issued through the control register. From that record it decides which FIFO the ready flag describes and which condition on that FIFO applies.

The flag goes to two places. A status bit in the control register is never gated, so a host with no ready input pin can poll it. An external ready pin is qualified by chip select. The FIFOs, the memory-side transfer engine and the address increment logic are outside the block. It sees only their full, empty, flush-in-progress and fill-complete flags, and it issues a one-cycle flush request when a prefetch is commanded.

Top module: `host_ready_tracker`

## Requirements
- R1: After reset, before any data access, `rdy_bit` equals `!wf_full`, and `fetch_bit` and `flush_req` are 0.
- R2: After an auto-increment write (`acc_is_write`=1, `acc_autoinc`=1), `rdy_bit` equals `!wf_full`.
- R3: After a fixed-address write (`acc_is_write`=1, `acc_autoinc`=0), `rdy_bit` equals `wf_empty`. It is low while data is still waiting to reach memory.
- R4: After an auto-increment read (`acc_is_write`=0, `acc_autoinc`=1), `rdy_bit` equals `!rf_empty && !rf_flushing`.
- R5: After a fixed-address read (`acc_is_write`=0, `acc_autoinc`=0), `rdy_bit` equals `!rf_flushing`, and stays high when the read FIFO is empty.
- R6: A control write with `ctl_fetch_in`=1 sets `fetch_bit` and `flush_req` to 1 in the following cycle only. If no further fetch write occurs, both return to 0 one cycle later.
- R7: After a fetch command, `rdy_bit` is 0 until a cycle in which `rf_loaded`=1 and `rf_flushing`=0. From then on it equals `!rf_flushing`. A load pulse that arrives during a flush does not count.
- R8: The access type is captured only on the 0-to-1 transition of `data_strb_n`, using `acc_is_write` and `acc_autoinc` in that cycle. An active strobe, or a control write with `ctl_fetch_in`=0, leaves the selection unchanged.
- R9: `rdy_bit` is not gated by `host_sel`. `rdy_pin` equals `rdy_bit` when `host_sel`=1 and is 0 otherwise.
- R10: When a fetch command and a strobe release fall in the same cycle, the fetch command sets the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host chip select, active high |
| data_strb_n | input | 1 | Internal data strobe, active low |
| acc_is_write | input | 1 | Access direction: 1 for write, 0 for read |
| acc_autoinc | input | 1 | Access addressing: 1 for auto-increment, 0 for fixed address |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_fetch_in | input | 1 | Fetch field of the control write data |
| wf_full | input | 1 | Write FIFO full |
| wf_empty | input | 1 | Write FIFO empty |
| rf_empty | input | 1 | Read FIFO empty |
| rf_flushing | input | 1 | Read FIFO flush in progress |
| rf_loaded | input | 1 | Read FIFO fill from memory complete |
| rdy_bit | output | 1 | Ungated ready status bit for the control register |
| rdy_pin | output | 1 | Ready output qualified by chip select |
| fetch_bit | output | 1 | Self-clearing fetch field of the control register |
| flush_req | output | 1 | One-cycle flush request to the read FIFO |

## Verification
The bench holds the strobe low across a change of access type and checks that the ready flag keeps following the old FIFO until the strobe releases. A design that captured on the active edge would switch early. It drives a fixed-address read into an empty read FIFO and expects ready high, which catches a design that treats this case like an auto-increment read. It sends a load pulse during a flush after a prefetch and expects ready to stay low, because a design that accepted that pulse would report stale data as ready. It also issues a fetch in the same cycle as a write release; a design that let the write win would raise ready from write FIFO space.

// File: rtl/host_ready_tracker.sv
module host_ready_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic host_sel,
  input  logic data_strb_n,
  input  logic acc_is_write,
  input  logic acc_autoinc,
  input  logic ctl_wr,
  input  logic ctl_fetch_in,
  input  logic wf_full,
  input  logic wf_empty,
  input  logic rf_empty,
  input  logic rf_flushing,
  input  logic rf_loaded,
  output logic rdy_bit,
  output logic rdy_pin,
  output logic fetch_bit,
  output logic flush_req
);

  typedef enum logic [2:0] {
    SEL_WDEF, SEL_WR_AI, SEL_WR_FX, SEL_RD_AI, SEL_RD_FX, SEL_FETCH
  } sel_t;

  sel_t sel;
  logic strb_q;
  logic fetch_done;

  wire release_edge = data_strb_n & ~strb_q;
  wire fetch_cmd    = ctl_wr & ctl_fetch_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q     <= 1'b1;
      sel        <= SEL_WDEF;
      fetch_done <= 1'b0;
      fetch_bit  <= 1'b0;
    end else begin
      strb_q    <= data_strb_n;
      fetch_bit <= fetch_cmd;
      if (fetch_cmd) begin
        sel        <= SEL_FETCH;
        fetch_done <= 1'b0;
      end else if (release_edge) begin
        case ({acc_is_write, acc_autoinc})
          2'b11:   sel <= SEL_WR_AI;
          2'b10:   sel <= SEL_WR_FX;
          2'b01:   sel <= SEL_RD_AI;
          default: sel <= SEL_RD_FX;
        endcase
      end else if (sel == SEL_FETCH && rf_loaded && !rf_flushing) begin
        fetch_done <= 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_WR_FX: rdy_bit = wf_empty;
      SEL_RD_AI: rdy_bit = ~rf_empty & ~rf_flushing;
      SEL_RD_FX: rdy_bit = ~rf_flushing;
      SEL_FETCH: rdy_bit = fetch_done & ~rf_flushing;
      default:   rdy_bit = ~wf_full;
    endcase
  end

  assign rdy_pin   = rdy_bit & host_sel;
  assign flush_req = fetch_bit;

  assert_fetch_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cmd |=> (fetch_bit && flush_req));
  assert_fetch_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_cmd |=> !flush_req);
  assert_fetch_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cmd |=> !rdy_bit);
  assert_fx_read_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_edge && !fetch_cmd && !acc_is_write && !acc_autoinc) |=> (rf_flushing || rdy_bit));
  assert_ai_write_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (release_edge && !fetch_cmd && acc_is_write && acc_autoinc) |=> (rdy_bit == !wf_full));
  assert_pin_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pin |-> (host_sel && rdy_bit));

endmodule

// File: tb/host_ready_tracker_test.sv
module host_ready_tracker_test;
  logic clk = 0, rst_n = 0;
  logic host_sel = 0, data_strb_n = 1, acc_is_write = 0, acc_autoinc = 0;
  logic ctl_wr = 0, ctl_fetch_in = 0;
  logic wf_full = 0, wf_empty = 1, rf_empty = 1, rf_flushing = 0, rf_loaded = 0;
  logic rdy_bit, rdy_pin, fetch_bit, flush_req;

  always #4 clk = ~clk;

  host_ready_tracker uut (.*);

  typedef struct {
    logic rdy, pin, fet, fl;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic tick(input logic rdy, input logic pin, input logic fet,
                      input logic fl, input string tag);
    exp_t e;
    @(posedge clk);
    e.rdy = rdy; e.pin = pin; e.fet = fet; e.fl = fl; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({rdy_bit, rdy_pin, fetch_bit, flush_req} !== {e.rdy, e.pin, e.fet, e.fl}) begin
        errors++;
        $display("FAIL %s rdy/pin/fetch/flush actual %b%b%b%b expected %b%b%b%b", e.tag,
                 rdy_bit, rdy_pin, fetch_bit, flush_req, e.rdy, e.pin, e.fet, e.fl);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(1, 0, 0, 0, "R1 reset state");
    wf_full = 1;           tick(0, 0, 0, 0, "R1 default tracks write space");
    host_sel = 1;          tick(0, 0, 0, 0, "R9 pin low when not ready");
    wf_full = 0;           tick(1, 1, 0, 0, "R9 pin follows when selected");
    host_sel = 0;          tick(1, 0, 0, 0, "R9 bit ungated by select");
    // fixed-address write, data pending
    wf_empty = 0; data_strb_n = 0; acc_is_write = 1; acc_autoinc = 0;
    tick(1, 0, 0, 0, "R8 no change while strobe active");
    data_strb_n = 1;       tick(0, 0, 0, 0, "R3 fixed write pending");
    wf_empty = 1;          tick(1, 0, 0, 0, "R3 fixed write drained");
    // auto-increment read
    data_strb_n = 0; acc_is_write = 0; acc_autoinc = 1;
    tick(1, 0, 0, 0, "R8 old selection held");
    data_strb_n = 1;       tick(0, 0, 0, 0, "R4 ai read empty");
    rf_empty = 0;          tick(1, 0, 0, 0, "R4 ai read data");
    rf_flushing = 1;       tick(0, 0, 0, 0, "R4 ai read flushing");
    rf_flushing = 0; ctl_wr = 1; ctl_fetch_in = 0;
    tick(1, 0, 0, 0, "R8 control write without fetch");
    ctl_wr = 0;
    // fixed-address read, empty FIFO
    rf_empty = 1; data_strb_n = 0; acc_autoinc = 0;
    tick(0, 0, 0, 0, "R8 ai read still selected");
    data_strb_n = 1;       tick(1, 0, 0, 0, "R5 fixed read empty stays ready");
    rf_flushing = 1;       tick(0, 0, 0, 0, "R5 fixed read flushing");
    rf_flushing = 0;       tick(1, 0, 0, 0, "R5 flush ended");
    // auto-increment write filling FIFO
    wf_full = 1; data_strb_n = 0; acc_is_write = 1; acc_autoinc = 1;
    tick(1, 0, 0, 0, "R8 fixed read still selected");
    data_strb_n = 1;       tick(0, 0, 0, 0, "R2 ai write full");
    wf_full = 0;           tick(1, 0, 0, 0, "R2 ai write space");
    // prefetch
    ctl_wr = 1; ctl_fetch_in = 1;
    tick(0, 0, 1, 1, "R6 fetch set and flush pulse");
    ctl_wr = 0;            tick(0, 0, 0, 0, "R6 fetch self-clears");
    rf_flushing = 1;       tick(0, 0, 0, 0, "R7 flushing");
    rf_flushing = 1; rf_loaded = 1;
    tick(0, 0, 0, 0, "R7 load during flush ignored");
    rf_flushing = 0; rf_loaded = 0;
    tick(0, 0, 0, 0, "R7 no load yet");
    rf_empty = 0; rf_loaded = 1;
    tick(1, 0, 0, 0, "R7 loaded");
    rf_loaded = 0;         tick(1, 0, 0, 0, "R7 stays ready");
    // fetch coincident with write release
    data_strb_n = 0; acc_is_write = 1; acc_autoinc = 1;
    tick(1, 0, 0, 0, "R8 fetch selection held");
    data_strb_n = 1; ctl_wr = 1; ctl_fetch_in = 1;
    tick(0, 0, 1, 1, "R10 fetch wins over release");
    ctl_wr = 0;            tick(0, 0, 0, 0, "R10 still on read FIFO");
    host_sel = 1; rf_loaded = 1;
    tick(1, 1, 0, 0, "R9 pin after fetch load");
    rf_loaded = 0;
    @(posedge clk); #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule